// File: doc/BRIEF.md
# Multiprocessor UART Address Filter Receiver

This block receives 9-bit serial frames on one line and decides which of them reach the host. A bus of several nodes shares the line. The ninth bit of each frame marks the frame as an address (1) or as data (0). While multiprocessor mode is on, the node compares each address frame against two patterns built from its own address register and its own mask register. One pattern is a per-bit masked "given" match. The other is a "broadcast" match taken from the address OR'd with the mask. Data frames reach the host only after an address frame that hit.

Nodes may hold the same address and still be told apart by their masks. For example, address 1100_0000 with mask 1111_1101 answers to 1100_00X0, and with mask 1111_1110 it answers to 1100_000X. Then 1100_0010 selects only the first node, 1100_0001 only the second, and 1100_0000 selects both. When the mode is off, every well-formed frame is delivered and no comparison is made. An accepted byte is held with a ready flag until the host pulses a clear. A frame that arrives while the flag is still up is dropped, and that loss is recorded.

Top module: `mpu_addr_rx`

## Requirements
- R1: A frame is one low start bit, eight data bits sent LSB first, a ninth bit, and a high stop bit. Each bit is taken at the middle of its period using 16x oversampling. A frame whose stop bit is sampled low is dropped without any effect.
- R2: A low pulse on the line that has ended before the middle of the start bit does not begin a frame and changes no output.
- R3: While `mp_en` is 0, every well-formed frame is accepted whatever its ninth bit. `given_hit` and `bcast_hit` are 0 from the cycle after `mp_en` is seen low.
- R4: Given match: for every bit i where `node_mask[i]` is 1, the received address bit i must equal `node_addr[i]`. Bits with mask 0 are ignored.
- R5: Broadcast match: every bit that is 1 in `node_addr | node_mask` must be 1 in the received address. The other bits are ignored.
- R6: With `mp_en` at 1, each well-formed address frame (ninth bit 1) loads `given_hit` and `bcast_hit` with its two match results. The frame itself is accepted only if at least one of them is 1.
- R7: With `mp_en` at 1, a data frame (ninth bit 0) is accepted only if the last address frame hit. It is dropped if no address frame has hit since reset, since mode entry, or since the last address frame missed.
- R8: Acceptance loads `rx_data` and `rx_ninth` and sets `rx_flag`. `rx_flag` stays 1 until `flag_clr` is pulsed. A `flag_clr` pulse clears both `rx_flag` and `overrun`.
- R9: A frame that would be accepted while `rx_flag` is 1 sets `overrun` and leaves `rx_data` and `rx_ninth` unchanged. An address frame still updates the match outputs.
- R10: After reset, `rx_flag`, `overrun`, `given_hit`, `bcast_hit`, `rx_data` and `rx_ninth` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| mp_en | input | 1 | Multiprocessor (address filter) mode enable |
| node_addr | input | 8 | This node's address |
| node_mask | input | 8 | Per-bit compare enable for the address |
| flag_clr | input | 1 | One-cycle pulse that clears the ready flag and overrun |
| rx_data | output | 8 | Last accepted byte |
| rx_ninth | output | 1 | Ninth bit of the last accepted frame |
| rx_flag | output | 1 | Byte-ready flag |
| overrun | output | 1 | A frame was lost because the flag was still set |
| given_hit | output | 1 | Last address frame matched the masked address |
| bcast_hit | output | 1 | Last address frame matched the broadcast pattern |

## Verification
The bench uses the two overlapping-node examples: same address, masks differing in bits 0 and 1. It confirms that each unique address picks exactly one node and that 1100_0000 picks both. A comparator that ignored the mask, or inverted it, would accept or drop the wrong one. Broadcast patterns that fail the given match are sent, along with data frames sent before any address and after a miss. A design that kept a stale selection, or that filtered by the given match alone, would then deliver or lose the wrong bytes. Short start glitches, low stop bits and frames arriving while the flag is held are also sent. These catch receivers that start on noise, deliver malformed frames, or overwrite unread data.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/mpu_rx_tick.sv
module mpu_rx_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt  <= cnt + 1'b1;
          tick <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rxd,
  output logic             done,
  output logic             stop_ok,
  output logic [NBITS-1:0] frame
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(NBITS);
  localparam int HALF = OVS / 2;

  logic [1:0]       sync;
  logic             rx_s;
  logic             prev_hi;
  rx_state_t        state;
  logic [CW-1:0]    ovs_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [NBITS-1:0] shreg;

  assign rx_s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      prev_hi <= 1'b0;
      ovs_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b0;
      frame   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            prev_hi <= rx_s;
            ovs_cnt <= '0;
            if (prev_hi && !rx_s) state <= RX_START;
          end
          RX_START: begin
            if (ovs_cnt == CW'(HALF - 1)) begin
              ovs_cnt <= '0;
              bit_cnt <= '0;
              if (!rx_s) begin
                state <= RX_BITS;
              end else begin
                state   <= RX_IDLE;
                prev_hi <= 1'b1;
              end
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (ovs_cnt == CW'(OVS - 1)) begin
              ovs_cnt <= '0;
              shreg   <= {rx_s, shreg[NBITS-1:1]};
              if (bit_cnt == BW'(NBITS - 1)) state <= RX_STOP;
              else                           bit_cnt <= bit_cnt + 1'b1;
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (ovs_cnt == CW'(OVS - 1)) begin
              ovs_cnt <= '0;
              done    <= 1'b1;
              stop_ok <= rx_s;
              frame   <= shreg;
              prev_hi <= rx_s;
              state   <= RX_IDLE;
            end else begin
              ovs_cnt <= ovs_cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpu_addr_cmp.sv
module mpu_addr_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] mask,
  output logic         given,
  output logic         bcast
);
  logic [W-1:0] g_ok;
  logic [W-1:0] b_ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g_ok[i] = !mask[i] || (rx_byte[i] == addr[i]);
    assign b_ok[i] = !(addr[i] || mask[i]) || rx_byte[i];
  end

  assign given = &g_ok;
  assign bcast = &b_ok;
endmodule

// File: rtl/mpu_addr_rx.sv
module mpu_addr_rx #(
  parameter int W        = 8,
  parameter int OVS      = 16,
  parameter int TICK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxd,
  input  logic         mp_en,
  input  logic [W-1:0] node_addr,
  input  logic [W-1:0] node_mask,
  input  logic         flag_clr,
  output logic [W-1:0] rx_data,
  output logic         rx_ninth,
  output logic         rx_flag,
  output logic         overrun,
  output logic         given_hit,
  output logic         bcast_hit
);
  localparam int NBITS = W + 1;

  logic           tick;
  logic           fr_done;
  logic           fr_stop_ok;
  logic [NBITS-1:0] fr_bits;
  logic           cmp_given;
  logic           cmp_bcast;
  logic           frame_ok;
  logic           is_addr;
  logic           addr_go;
  logic           accept;
  logic           flag_keep;
  logic           ovr_keep;

  mpu_rx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  mpu_rx_frame #(.OVS(OVS), .NBITS(NBITS)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .rxd    (rxd),
    .done   (fr_done),
    .stop_ok(fr_stop_ok),
    .frame  (fr_bits)
  );

  mpu_addr_cmp #(.W(W)) u_cmp (
    .rx_byte(fr_bits[W-1:0]),
    .addr   (node_addr),
    .mask   (node_mask),
    .given  (cmp_given),
    .bcast  (cmp_bcast)
  );

  always_comb begin
    frame_ok  = fr_done && fr_stop_ok;
    is_addr   = fr_bits[NBITS-1];
    addr_go   = mp_en && frame_ok && is_addr;
    if (!mp_en)      accept = frame_ok;
    else if (is_addr) accept = frame_ok && (cmp_given || cmp_bcast);
    else              accept = frame_ok && (given_hit || bcast_hit);
    flag_keep = rx_flag && !flag_clr;
    ovr_keep  = overrun && !flag_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      given_hit <= 1'b0;
      bcast_hit <= 1'b0;
    end else if (!mp_en) begin
      given_hit <= 1'b0;
      bcast_hit <= 1'b0;
    end else if (addr_go) begin
      given_hit <= cmp_given;
      bcast_hit <= cmp_bcast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ninth <= 1'b0;
      rx_flag  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      rx_flag <= flag_keep;
      overrun <= ovr_keep;
      if (accept) begin
        if (flag_keep) begin
          overrun <= 1'b1;
        end else begin
          rx_data  <= fr_bits[W-1:0];
          rx_ninth <= is_addr;
          rx_flag  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mpu_addr_rx_chk.sv
module mpu_addr_rx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mp_en,
  input logic         flag_clr,
  input logic [W-1:0] rx_data,
  input logic         rx_ninth,
  input logic         rx_flag,
  input logic         overrun,
  input logic         given_hit,
  input logic         bcast_hit
);
  AST_ADDR_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $past(mp_en) && $rose(rx_flag) && rx_ninth |-> (given_hit || bcast_hit)); // R6

  AST_DATA_FLAG_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    $past(mp_en) && $rose(rx_flag) && !rx_ninth |-> (given_hit || bcast_hit)); // R7

  AST_HITS_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !mp_en |=> (!given_hit && !bcast_hit)); // R3

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    rx_flag && !flag_clr |=> rx_flag); // R8

  AST_CLR_DROPS_OVR: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !overrun); // R8

  AST_DATA_KEPT_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_flag && !flag_clr |=> ($stable(rx_data) && $stable(rx_ninth))); // R9

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_flag)); // R9
endmodule

bind mpu_addr_rx mpu_addr_rx_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mp_en    (mp_en),
  .flag_clr (flag_clr),
  .rx_data  (rx_data),
  .rx_ninth (rx_ninth),
  .rx_flag  (rx_flag),
  .overrun  (overrun),
  .given_hit(given_hit),
  .bcast_hit(bcast_hit)
);

// File: tb/mpu_addr_rx_tb_top.sv
module mpu_addr_rx_tb_top;
  localparam int W        = 8;
  localparam int OVS      = 16;
  localparam int TICK_DIV = 4;
  localparam int BITCLK   = OVS * TICK_DIV;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rxd = 1'b1;
  logic         mp_en = 1'b0;
  logic [W-1:0] node_addr = '0;
  logic [W-1:0] node_mask = '0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] rx_data;
  logic         rx_ninth;
  logic         rx_flag;
  logic         overrun;
  logic         given_hit;
  logic         bcast_hit;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit busy     = 1'b1;
  bit finished = 1'b0;

  // reference model state
  logic [W-1:0] m_data  = '0;
  logic         m_ninth = 1'b0;
  logic         m_flag  = 1'b0;
  logic         m_ovr   = 1'b0;
  logic         m_given = 1'b0;
  logic         m_bcast = 1'b0;

  always #5 clk = ~clk;

  mpu_addr_rx #(.W(W), .OVS(OVS), .TICK_DIV(TICK_DIV)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .rxd      (rxd),
    .mp_en    (mp_en),
    .node_addr(node_addr),
    .node_mask(node_mask),
    .flag_clr (flag_clr),
    .rx_data  (rx_data),
    .rx_ninth (rx_ninth),
    .rx_flag  (rx_flag),
    .overrun  (overrun),
    .given_hit(given_hit),
    .bcast_hit(bcast_hit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model while the bench is quiet
  always @(negedge clk) begin
    cycles++;
    if (!busy && !finished) begin
      chk("R8 flag (per-clock)", int'(rx_flag), int'(m_flag));
      chk("R9 overrun (per-clock)", int'(overrun), int'(m_ovr));
      chk("R8 data (per-clock)", int'(rx_data), int'(m_data));
      chk("R8 ninth (per-clock)", int'(rx_ninth), int'(m_ninth));
      chk("R6 given (per-clock)", int'(given_hit), int'(m_given));
      chk("R6 bcast (per-clock)", int'(bcast_hit), int'(m_bcast));
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic bit ref_given(input logic [W-1:0] b, input logic [W-1:0] a,
                                   input logic [W-1:0] m);
    bit ok = 1'b1;
    for (int i = 0; i < W; i++) if (m[i] && (b[i] != a[i])) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit ref_bcast(input logic [W-1:0] b, input logic [W-1:0] a,
                                   input logic [W-1:0] m);
    bit ok = 1'b1;
    for (int i = 0; i < W; i++) if ((a[i] || m[i]) && !b[i]) ok = 1'b0;
    return ok;
  endfunction

  task automatic model_frame(input logic [W-1:0] b, input logic nb, input logic stp);
    bit acc;
    if (!stp) return;
    if (!mp_en) begin
      acc = 1'b1;
    end else if (nb) begin
      m_given = ref_given(b, node_addr, node_mask);
      m_bcast = ref_bcast(b, node_addr, node_mask);
      acc = m_given || m_bcast;
    end else begin
      acc = m_given || m_bcast;
    end
    if (acc) begin
      if (m_flag) m_ovr = 1'b1;
      else begin
        m_data = b; m_ninth = nb; m_flag = 1'b1;
      end
    end
  endtask

  task automatic send(input logic [W-1:0] b, input logic nb, input logic stp = 1'b1);
    busy = 1'b1;
    @(negedge clk) rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < W; i++) begin
      rxd = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = nb;
    repeat (BITCLK) @(negedge clk);
    rxd = stp;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
    model_frame(b, nb, stp);
    busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    busy = 1'b1;
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    m_flag = 1'b0;
    m_ovr  = 1'b0;
    @(negedge clk);
    busy = 1'b0;
  endtask

  task automatic config_node(input logic mp, input logic [W-1:0] a, input logic [W-1:0] m);
    busy = 1'b1;
    @(negedge clk);
    mp_en = mp; node_addr = a; node_mask = m;
    if (!mp) begin m_given = 1'b0; m_bcast = 1'b0; end
    repeat (3) @(negedge clk);
    busy = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 flag", int'(rx_flag), 0);
    chk("R10 overrun", int'(overrun), 0);
    chk("R10 hits", int'({given_hit, bcast_hit}), 0);
    chk("R10 data", int'({rx_ninth, rx_data}), 0);
    busy = 1'b0;

    // R1 / R3: mode off, plain frames, LSB first
    config_node(1'b0, 8'hC0, 8'hFD);
    send(8'h5A, 1'b0);
    chk("R1 data LSB first", int'(rx_data), 'h5A);
    chk("R3 accepted with mode off", int'(rx_flag), 1);
    clear_flag();
    chk("R8 clear", int'(rx_flag), 0);
    send(8'h13, 1'b1);
    chk("R3 ninth=1 accepted, no compare", int'({rx_flag, rx_ninth, given_hit, bcast_hit}), 'b1100);
    clear_flag();

    // R2 start glitch
    busy = 1'b1;
    @(negedge clk) rxd = 1'b0;
    repeat (BITCLK / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    chk("R2 glitch ignored", int'(rx_flag), 0);

    // R1 framing error
    send(8'hA5, 1'b0, 1'b0);
    chk("R1 bad stop dropped", int'(rx_flag), 0);
    send(8'h77, 1'b0);
    chk("R1 recover after bad stop", int'(rx_data), 'h77);
    clear_flag();

    // R7 data before any address is dropped
    config_node(1'b1, 8'hC0, 8'hFD);
    send(8'h44, 1'b0);
    chk("R7 data before address dropped", int'(rx_flag), 0);

    // R4 slave-0 example
    send(8'hC2, 1'b1);
    chk("R4 C2 given for mask FD", int'({given_hit, bcast_hit}), 'b10);
    chk("R6 address accepted", int'({rx_flag, rx_ninth, rx_data}), 'h3C2);
    clear_flag();
    send(8'h33, 1'b0);
    chk("R7 data after hit", int'(rx_data), 'h33);
    clear_flag();
    send(8'hC1, 1'b1);
    chk("R4 C1 misses mask FD", int'({given_hit, bcast_hit, rx_flag}), 0);
    send(8'h34, 1'b0);
    chk("R7 data after miss dropped", int'(rx_flag), 0);
    send(8'hC0, 1'b1);
    chk("R4 C0 group addr, mask FD", int'(given_hit), 1);
    clear_flag();

    // R4 slave-1 example
    config_node(1'b1, 8'hC0, 8'hFE);
    send(8'hC1, 1'b1);
    chk("R4 C1 given for mask FE", int'(given_hit), 1);
    clear_flag();
    send(8'hC2, 1'b1);
    chk("R4 C2 misses mask FE", int'({given_hit, rx_flag}), 0);
    send(8'hC0, 1'b1);
    chk("R4 C0 group addr, mask FE", int'(given_hit), 1);
    clear_flag();

    // R5 broadcast
    config_node(1'b1, 8'hC0, 8'hFD);
    send(8'hFF, 1'b1);
    chk("R5 FF broadcast only", int'({given_hit, bcast_hit}), 'b01);
    clear_flag();
    send(8'hFD, 1'b1);
    chk("R5 FD broadcast", int'(bcast_hit), 1);
    clear_flag();
    send(8'hF9, 1'b1);
    chk("R5 F9 no broadcast", int'({bcast_hit, rx_flag}), 0);

    // R9 overrun
    send(8'hC0, 1'b1);
    send(8'h66, 1'b0);
    chk("R9 overrun set", int'(overrun), 1);
    chk("R9 data kept", int'(rx_data), 'hC0);
    clear_flag();
    chk("R8 clear drops overrun", int'({rx_flag, overrun}), 0);

    // R3 leaving mode clears hits
    config_node(1'b0, 8'hC0, 8'hFD);
    chk("R3 hits cleared when off", int'({given_hit, bcast_hit}), 0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule